// File: doc/BRIEF.md
# Power Management Wake Status Register

This block is one 32-bit control and status word that a network controller uses for power management. Two detectors feed it one-cycle pulses: a wake-up frame matcher with four pattern outputs, and a magic-packet recogniser. Each detector also supplies an enable level. An enabled pulse sets a sticky event bit and that detector's own flag. Software can also enable an active-low event line. The line is driven low while the event bit and the enable bit are both 1. The same word holds the device power state, which software writes.

The host reaches the word through a simple beat port. The address is a word address, the write data is split into four byte lanes with one enable each, and read data is combinational. The port takes only the first beat of a burst and raises a disconnect for the rest. Software clears the event bit and all five detector flags with a single write of 1 to the event bit. A move from D3hot to D0 turns the event enable off. A software-reset pulse returns the power state and the enable to their reset values. It leaves the latched wake history in place.

Top module: `pm_wake_csr`

## Requirements
- R1: Bit 15 of the word (the event bit) becomes 1 one cycle after `wf_en` is high together with any bit of `wf_hit`, or after `mp_en` is high together with `mp_hit`. A pulse whose enable is low changes neither the event bit nor any flag.
- R2: `pme_n` is 0 exactly while the event bit and bit 8 (the event enable) are both 1, and 1 otherwise.
- R3: An accepted write with lane 1 enabled and data bit 15 = 1 clears the event bit, all `wf_flag` bits and `mp_flag`. A write with data bit 15 = 0, or with lane 1 disabled, leaves all of them unchanged.
- R4: If an enabled detector pulse arrives in the same cycle as a clear, the pulse wins. The event bit stays 1 and the pulsing detector's flag is 1. All other flags are cleared.
- R5: `wf_flag[i]` is set by `wf_hit[i]` while `wf_en` is high, and `mp_flag` is set by `mp_hit` while `mp_en` is high. Each flag holds its value until a clear (R3).
- R6: Bit 8 is written from data bit 8 through lane 1. A write through lane 0 that moves the power state from 11 (D3hot) to 00 (D0) forces bit 8 to 0.
- R7: Bits 1:0 hold the power state (00 = D0, 01 = D1, 11 = D3hot) and are written through lane 0. A write of 10 leaves the field unchanged.
- R8: Bits 31:16, 14:9 and 7:2 always read 0 and ignore writes. A lane whose byte enable is 0 does not change any bit it holds.
- R9: A read whose address differs from `REG_ADDR` returns 0 on `bus_rdata`.
- R10: A beat with `bus_more` = 1 is carried out and raises `bus_disc`. Every further beat is ignored, with `bus_disc` high, until `bus_valid` goes low.
- R11: A `soft_rst` pulse sets the power state to 00 and bit 8 to 0 and keeps the event bit and all flags. `rst_n` low clears everything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| soft_rst | input | 1 | Synchronous software-reset pulse |
| bus_valid | input | 1 | A host beat is present |
| bus_wr | input | 1 | 1 = write beat, 0 = read beat |
| bus_more | input | 1 | The host intends another beat after this one |
| bus_addr | input | ADDR_W | Word address |
| bus_be | input | 4 | Byte-lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 unless this is an accepted read of the register |
| bus_disc | output | 1 | Disconnect: the beats after this one will not be transferred |
| wf_en | input | 1 | Wake-frame detector enable |
| wf_hit | input | NUM_PAT | Per-pattern wake-frame match pulses |
| mp_en | input | 1 | Magic-packet detector enable |
| mp_hit | input | 1 | Magic-packet received pulse |
| wf_flag | output | NUM_PAT | Latched wake-frame pattern flags |
| mp_flag | output | 1 | Latched magic-packet flag |
| pme_n | output | 1 | Active-low power-management event |

## Verification
The assertions check several rules on every cycle: an enabled pulse sets the event bit on the next cycle, a clear with no competing event empties it, a flag with no pulse and no clear keeps its value, the power-state field never holds 10, D3hot-to-D0 drops the enable, reads of other addresses return zero, and the beat after a burst start is refused. Other behaviours can only be seen in the bench scenarios. These are lane masking across all four enables, the ignored state code combined with reserved-bit writes, the clear and the event landing in one cycle, the burst sequence as the host sees it, and the difference between the software reset and the hardware reset.

// File: rtl/pm_wake_pkg.sv
package pm_wake_pkg;
   localparam int REG_W   = 32;
   localparam int LANE_W  = 8;
   localparam int BE_W    = REG_W / LANE_W;
   localparam int STS_BIT = 15;
   localparam int EN_BIT  = 8;
   localparam int PS_LSB  = 0;

   typedef enum logic [1:0] {
      PS_D0  = 2'b00,
      PS_D1  = 2'b01,
      PS_BAD = 2'b10,
      PS_D3  = 2'b11
   } pstate_e;
endpackage

// File: rtl/pm_csr_port.sv
module pm_csr_port #(
   parameter int ADDR_W   = 6,
   parameter int REG_ADDR = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_wr,
   input  logic              bus_more,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              wr_hit,
   output logic              rd_hit,
   output logic              bus_disc
);
   logic hold_q;
   logic beat_ok;
   logic addr_hit;

   assign beat_ok  = bus_valid && !hold_q;
   assign addr_hit = (bus_addr == ADDR_W'(REG_ADDR));
   assign wr_hit   = beat_ok && bus_wr && addr_hit;
   assign rd_hit   = beat_ok && !bus_wr && addr_hit;
   assign bus_disc = bus_valid && (hold_q || bus_more);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   hold_q <= 1'b0;
      else if (!bus_valid)          hold_q <= 1'b0;
      else if (beat_ok && bus_more) hold_q <= 1'b1;
   end

   AST_BURST_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_ok && bus_more) |=> (!bus_valid || !(wr_hit || rd_hit))); // R10
endmodule

// File: rtl/pm_wake_latch.sv
module pm_wake_latch #(
   parameter int NUM_PAT = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               wf_en,
   input  logic [NUM_PAT-1:0] wf_hit,
   input  logic               mp_en,
   input  logic               mp_hit,
   output logic               sts_q,
   output logic [NUM_PAT-1:0] wf_flag,
   output logic               mp_flag
);
   logic evt;
   assign evt = (wf_en && (|wf_hit)) || (mp_en && mp_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sts_q <= 1'b0;
      else if (evt) sts_q <= 1'b1;
      else if (clr) sts_q <= 1'b0;
   end

   for (genvar i = 0; i < NUM_PAT; i++) begin : g_pat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   wf_flag[i] <= 1'b0;
         else if (wf_en && wf_hit[i])  wf_flag[i] <= 1'b1;
         else if (clr)                 wf_flag[i] <= 1'b0;
      end

      AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr && !(wf_en && wf_hit[i])) |=> $stable(wf_flag[i])); // R5
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                mp_flag <= 1'b0;
      else if (mp_en && mp_hit)  mp_flag <= 1'b1;
      else if (clr)              mp_flag <= 1'b0;
   end

   AST_EVT_SETS_STS: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> sts_q); // R1
   AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !evt) |=> (!sts_q && !mp_flag && (wf_flag == '0))); // R3
endmodule

// File: rtl/pm_pstate.sv
module pm_pstate
   import pm_wake_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    soft_rst,
   input  logic    wr_lo,
   input  logic    wr_hi,
   input  logic [1:0] wd_state,
   input  logic    wd_en,
   output pstate_e state_q,
   output logic    en_q
);
   pstate_e nxt_state;
   logic    d3_to_d0;

   always_comb begin
      nxt_state = state_q;
      if (wr_lo && (wd_state != PS_BAD)) nxt_state = pstate_e'(wd_state);
   end

   assign d3_to_d0 = (state_q == PS_D3) && (nxt_state == PS_D0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PS_D0;
         en_q    <= 1'b0;
      end else if (soft_rst) begin
         state_q <= PS_D0;
         en_q    <= 1'b0;
      end else begin
         state_q <= nxt_state;
         if (d3_to_d0)   en_q <= 1'b0;
         else if (wr_hi) en_q <= wd_en;
      end
   end

   AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      state_q != PS_BAD); // R7
   AST_EN_DROP_D3_D0: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && (state_q == PS_D3) && (wd_state == PS_D0)) |=> !en_q); // R6
endmodule

// File: rtl/pm_wake_csr.sv
module pm_wake_csr
   import pm_wake_pkg::*;
#(
   parameter int ADDR_W   = 6,
   parameter int REG_ADDR = 16,
   parameter int NUM_PAT  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               soft_rst,
   input  logic               bus_valid,
   input  logic               bus_wr,
   input  logic               bus_more,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [BE_W-1:0]    bus_be,
   input  logic [REG_W-1:0]   bus_wdata,
   output logic [REG_W-1:0]   bus_rdata,
   output logic               bus_disc,
   input  logic               wf_en,
   input  logic [NUM_PAT-1:0] wf_hit,
   input  logic               mp_en,
   input  logic               mp_hit,
   output logic [NUM_PAT-1:0] wf_flag,
   output logic               mp_flag,
   output logic               pme_n
);
   localparam int STS_LANE = STS_BIT / LANE_W;
   localparam int EN_LANE  = EN_BIT / LANE_W;
   localparam int PS_LANE  = PS_LSB / LANE_W;

   initial begin
      AST_PARAM_ADDR: assert (REG_ADDR >= 0 && REG_ADDR < (1 << ADDR_W)); // R9
      AST_PARAM_PAT:  assert (NUM_PAT >= 1 && NUM_PAT <= 16);             // R5
   end

   logic    wr_hit, rd_hit;
   logic    sts_q, en_q;
   pstate_e state_q;
   logic    clr;
   logic [REG_W-1:0] word;

   pm_csr_port #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_port (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_wr(bus_wr),
      .bus_more(bus_more), .bus_addr(bus_addr), .wr_hit(wr_hit),
      .rd_hit(rd_hit), .bus_disc(bus_disc));

   assign clr = wr_hit && bus_be[STS_LANE] && bus_wdata[STS_BIT];

   pm_wake_latch #(.NUM_PAT(NUM_PAT)) u_latch (
      .clk(clk), .rst_n(rst_n), .clr(clr), .wf_en(wf_en), .wf_hit(wf_hit),
      .mp_en(mp_en), .mp_hit(mp_hit), .sts_q(sts_q), .wf_flag(wf_flag),
      .mp_flag(mp_flag));

   pm_pstate u_pstate (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .wr_lo(wr_hit && bus_be[PS_LANE]),
      .wr_hi(wr_hit && bus_be[EN_LANE]),
      .wd_state(bus_wdata[PS_LSB +: 2]), .wd_en(bus_wdata[EN_BIT]),
      .state_q(state_q), .en_q(en_q));

   always_comb begin
      word               = '0;
      word[STS_BIT]      = sts_q;
      word[EN_BIT]       = en_q;
      word[PS_LSB +: 2]  = state_q;
   end

   assign bus_rdata = rd_hit ? word : '0;
   assign pme_n     = !(sts_q && en_q);

   AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_wr && (bus_addr != ADDR_W'(REG_ADDR))) |-> (bus_rdata == '0)); // R9
   AST_PME_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sts_q) && $stable(en_q) && en_q) |-> !pme_n); // R2
endmodule

// File: tb/pm_wake_csr_tb_top.sv
module pm_wake_csr_tb_top;
   localparam int ADDR_W = 6;
   localparam int RADDR  = 16;
   localparam int NP     = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic soft_rst = 1'b0;
   logic bus_valid = 1'b0, bus_wr = 1'b0, bus_more = 1'b0;
   logic [ADDR_W-1:0] bus_addr = ADDR_W'(RADDR);
   logic [3:0]  bus_be = 4'h0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic        bus_disc;
   logic        wf_en = 1'b0, mp_en = 1'b0, mp_hit = 1'b0;
   logic [NP-1:0] wf_hit = '0;
   logic [NP-1:0] wf_flag;
   logic        mp_flag, pme_n;

   int n_chk = 0, n_bad = 0;
   logic [31:0] rd;

   always #10 clk = ~clk;

   pm_wake_csr #(.ADDR_W(ADDR_W), .REG_ADDR(RADDR), .NUM_PAT(NP)) dut_i (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bus_valid(bus_valid),
      .bus_wr(bus_wr), .bus_more(bus_more), .bus_addr(bus_addr),
      .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_disc(bus_disc), .wf_en(wf_en), .wf_hit(wf_hit), .mp_en(mp_en),
      .mp_hit(mp_hit), .wf_flag(wf_flag), .mp_flag(mp_flag), .pme_n(pme_n));

   // {byte enables, write data, expected word read back afterwards}
   localparam int NV = 11;
   localparam logic [67:0] VEC [0:NV-1] = '{
      {4'hF, 32'h0000_0101, 32'h0000_0101},  // R7 D1, R6 enable on
      {4'hF, 32'h0000_0102, 32'h0000_0101},  // R7 code 10 ignored
      {4'hF, 32'hFFFF_7FFF, 32'h0000_0103},  // R8 reserved ignored, D3
      {4'h1, 32'h0000_0000, 32'h0000_0000},  // R6 D3->D0 drops enable
      {4'h2, 32'h0000_0100, 32'h0000_0100},  // R6 enable via lane 1
      {4'h1, 32'h0000_0003, 32'h0000_0103},  // R7 D3
      {4'h2, 32'h0000_0000, 32'h0000_0003},  // R6 enable off
      {4'hC, 32'hFFFF_FFFF, 32'h0000_0003},  // R8 disabled lanes
      {4'h1, 32'h0000_0001, 32'h0000_0001},  // R7 D3->D1
      {4'h2, 32'h0000_0100, 32'h0000_0101},  // R6
      {4'h1, 32'h0000_0000, 32'h0000_0100}   // R6 D1->D0 keeps enable
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_wr = 1'b1; bus_more = 1'b0;
      bus_addr = ADDR_W'(RADDR); bus_be = be; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_wr = 1'b0; bus_be = 4'h0;
   endtask

   task automatic rdw(input logic [ADDR_W-1:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_valid = 1'b1; bus_wr = 1'b0; bus_more = 1'b0; bus_addr = a;
      #2 v = bus_rdata;
      bus_valid = 1'b0; bus_addr = ADDR_W'(RADDR);
   endtask

   task automatic pulse_wf(input logic [NP-1:0] h);
      @(negedge clk); wf_hit = h;
      @(negedge clk); wf_hit = '0;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      #(20 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rdw(ADDR_W'(RADDR), rd);
      check("R11 reset word", rd, 32'h0);
      check("R2 reset pme_n", {31'b0, pme_n}, 32'h1);
      check("R5 reset flags", {27'b0, mp_flag, wf_flag}, 32'h0);

      for (int k = 0; k < NV; k++) begin
         wr(VEC[k][67:64], VEC[k][63:32]);
         rdw(ADDR_W'(RADDR), rd);
         check($sformatf("R6/R7/R8 vector %0d", k), rd, VEC[k][31:0]);
      end

      // state D0, enable 1
      wf_en = 1'b1;
      pulse_wf(4'b0100);
      rdw(ADDR_W'(RADDR), rd);
      check("R1 frame event sets bit 15", rd, 32'h0000_8100);
      check("R2 pme_n low", {31'b0, pme_n}, 32'h0);
      check("R5 frame flag", {28'b0, wf_flag}, 32'h4);

      wf_en = 1'b0; mp_en = 1'b0;
      pulse_wf(4'b0001);
      @(negedge clk); mp_hit = 1'b1; @(negedge clk); mp_hit = 1'b0;
      check("R1 disabled pulses ignored", {27'b0, mp_flag, wf_flag}, 32'h04);

      mp_en = 1'b1;
      @(negedge clk); mp_hit = 1'b1; @(negedge clk); mp_hit = 1'b0;
      check("R5 magic flag", {31'b0, mp_flag}, 32'h1);

      wr(4'h2, 32'h0000_0100);
      wr(4'h1, 32'h0000_8000);
      rdw(ADDR_W'(RADDR), rd);
      check("R3 no clear on 0 or lane off", rd, 32'h0000_8100);
      check("R3 flags kept", {27'b0, mp_flag, wf_flag}, 32'h14);

      wr(4'h2, 32'h0000_8100);
      rdw(ADDR_W'(RADDR), rd);
      check("R3 clear bit 15", rd, 32'h0000_0100);
      check("R3 flags cleared", {27'b0, mp_flag, wf_flag}, 32'h00);
      check("R2 pme_n high after clear", {31'b0, pme_n}, 32'h1);

      wf_en = 1'b1;
      pulse_wf(4'b1000);
      @(negedge clk);
      bus_valid = 1'b1; bus_wr = 1'b1; bus_be = 4'h2; bus_wdata = 32'h0000_8100;
      wf_hit = 4'b0010;
      @(negedge clk);
      bus_valid = 1'b0; bus_wr = 1'b0; bus_be = 4'h0; wf_hit = '0;
      rdw(ADDR_W'(RADDR), rd);
      check("R4 event beats clear", rd, 32'h0000_8100);
      check("R4 only new flag", {27'b0, mp_flag, wf_flag}, 32'h02);

      // burst: first beat goes in, the next is refused
      @(negedge clk);
      bus_valid = 1'b1; bus_wr = 1'b1; bus_more = 1'b1; bus_be = 4'hF;
      bus_wdata = 32'h0000_0101;
      #2 check("R10 disc on first beat", {31'b0, bus_disc}, 32'h1);
      @(negedge clk);
      bus_more = 1'b0; bus_wdata = 32'h0000_0003;
      #2 check("R10 disc on later beat", {31'b0, bus_disc}, 32'h1);
      @(negedge clk);
      bus_valid = 1'b0; bus_wr = 1'b0; bus_be = 4'h0;
      rdw(ADDR_W'(RADDR), rd);
      check("R10 only first beat written", rd, 32'h0000_8101);

      rdw(ADDR_W'(RADDR + 1), rd);
      check("R9 other address reads 0", rd, 32'h0);

      @(negedge clk); soft_rst = 1'b1;
      @(negedge clk); soft_rst = 1'b0;
      rdw(ADDR_W'(RADDR), rd);
      check("R11 soft reset keeps status", rd, 32'h0000_8000);
      check("R11 soft reset keeps flags", {27'b0, mp_flag, wf_flag}, 32'h02);

      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      rdw(ADDR_W'(RADDR), rd);
      check("R11 hw reset word", rd, 32'h0);
      check("R11 hw reset flags", {27'b0, mp_flag, wf_flag}, 32'h0);

      finish_run();
   end
endmodule